// File: doc/BRIEF.md
# Cascaded Up/Down Pulse Decimator

This block sits behind the comparator of a counting analog-to-digital converter. Each fast clock, the comparator may raise an "increment" pulse, a "decrement" pulse, both, or neither. The block nets the two into a signed step of -1, 0 or +1. It then integrates and decimates the stream through a chain of counting stages.

Every stage keeps its previous input sample in a one-sample delay cell. Each new sample is added to that held sample before accumulation, which averages over pairs. The first stage counts the paired sum every clock. After every second input sample, a stage hands its total to the next stage and restarts from zero. Each later stage is therefore fed at half the rate of the one before it, and it is two bits wider. Every stage presents its latest total as a parallel word with a one-cycle valid strobe. The words of alternate stages are complemented. A constant mask marks the lowest quarter of each word as quantization noise.

Top module: `updn_decimator`

## Requirements
- R1: When increment and decrement are both high in the same cycle, that cycle's step is zero. The step is +1 for increment alone, -1 for decrement alone and 0 for neither.
- R2: In the first stage, the amount added in each cycle is that cycle's step plus the previous cycle's step. The previous step is 0 in the first cycle after reset.
- R3: Every later stage takes the totals dumped by the stage before it as its input samples. It adds each sample to the sample before it, which is 0 for its first sample after reset.
- R4: On its second, fourth, sixth and later input samples, a stage outputs its accumulated total including that sample's paired sum. It then restarts from zero, so no amount is carried into the next interval.
- R5: The valid strobe of stage k (k = 0 for the first stage) is a single-cycle pulse. Consecutive pulses are exactly 2^(k+1) clock cycles apart.
- R6: Stage k produces a (4+2k)-bit two's-complement total. Its word occupies bits [k*4 + k*(k-1) +: 4+2k] of the output bus.
- R7: Stages 0 and 2 present the bitwise complement of their total. Stages 1 and 3 present the total unchanged.
- R8: In each stage's field of the noise mask, the lowest floor((4+2k)/4) bits are 1 and all other bits are 0.
- R9: After reset, all valid strobes are 0. Every word shows a total of zero in its stage's coding: all ones for the complemented stages and all zeros for the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_i | input | 1 | Increment pulse for this cycle |
| dec_i | input | 1 | Decrement pulse for this cycle |
| word_o | output | 28 | Packed stage words, stage 0 in the low bits |
| valid_o | output | 4 | One-cycle strobe per stage, bit k for stage k |
| noise_o | output | 28 | Mask of bits that are not significant, same packing as word_o |

## Verification
The bench runs a long stretch of simultaneous increment and decrement pulses. A faulty corrector would count these and push every stage away from zero. Isolated single pulses check the pair averaging: a design without the delay cell would report half the expected total, and one that cleared the delay cell on a dump would lose the carried sample. The bench measures the spacing of the strobes of every stage, which catches a divider chain that starts on the wrong phase or a dump that fires on odd samples. Random and full-scale streams are compared against a model, which exposes a dump that drops the final sample or a counter that is not cleared after a readout. The model also checks the sign convention and the coding of each stage.

// File: rtl/updn_decim_pkg.sv
package updn_decim_pkg;

    // Width of stage k given the first stage width
    function automatic int stage_width(input int k, input int w0);
        return w0 + 2 * k;
    endfunction

    // Bit offset of stage k inside the packed output bus
    function automatic int stage_offset(input int k, input int w0);
        return k * w0 + k * (k - 1);
    endfunction

    // Total bus width for n stages
    function automatic int bus_width(input int n, input int w0);
        return n * w0 + n * (n - 1);
    endfunction

endpackage

// File: rtl/updn_net.sv
module updn_net (
    input  logic              inc_i,
    input  logic              dec_i,
    output logic signed [1:0] step_o
);
    always_comb begin
        unique case ({inc_i, dec_i})
            2'b10:   step_o = 2'sb01;
            2'b01:   step_o = 2'sb11;
            default: step_o = 2'sb00;
        endcase
    end
endmodule

// File: rtl/updn_stage.sv
module updn_stage #(
    parameter int WI     = 2,
    parameter int W      = 4,
    parameter bit INVERT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [WI-1:0] in_val,
    output logic                 out_vld,
    output logic signed [W-1:0]  out_val,
    output logic [W-1:0]         word_o
);
    localparam int AW = W + 2;
    localparam logic signed [AW-1:0] MAXV = AW'((1 << (W - 1)) - 1);
    localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

    typedef struct packed {
        logic                 phase;
        logic                 vld;
        logic signed [WI-1:0] prev;
        logic signed [W-1:0]  cnt;
        logic signed [W-1:0]  val;
    } state_t;

    state_t st_d, st_q;
    logic signed [AW-1:0] pair_sum;
    logic signed [AW-1:0] acc;
    logic signed [W-1:0]  acc_sat;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        pair_sum = AW'(in_val) + AW'(st_q.prev);
        acc      = AW'(st_q.cnt) + pair_sum;
        if (acc > MAXV)      acc_sat = W'(MAXV);
        else if (acc < MINV) acc_sat = W'(MINV);
        else                 acc_sat = W'(acc);
        if (in_vld) begin
            st_d.prev  = in_val;
            st_d.phase = ~st_q.phase;
            if (st_q.phase) begin
                st_d.val = acc_sat;
                st_d.cnt = '0;
                st_d.vld = 1'b1;
            end else begin
                st_d.cnt = acc_sat;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_val = st_q.val;

    generate
        if (INVERT) begin : g_inv
            assign word_o = ~st_q.val;
        end else begin : g_true
            assign word_o = st_q.val;
        end
    endgenerate

    // R5: a strobe is always caused by an input sample one cycle earlier
    a_r5_strobe_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld));
    // R5: strobes never come back to back
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);
    // R4: the counter is empty right after a dump
    a_r4_cleared_on_dump: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (st_q.cnt == '0));
    // R3: the delay cell holds the last accepted sample
    a_r3_delay_cell: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (st_q.prev == $past(in_val)));
endmodule

// File: rtl/updn_decimator.sv
module updn_decimator
    import updn_decim_pkg::*;
#(
    parameter int NSTAGE = 4,
    parameter int W0     = 4,
    localparam int BW    = NSTAGE * W0 + NSTAGE * (NSTAGE - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    output logic [BW-1:0]     word_o,
    output logic [NSTAGE-1:0] valid_o,
    output logic [BW-1:0]     noise_o
);
    logic signed [1:0] step;
    logic [BW-1:0]     val_bus;

    updn_net u_net (
        .inc_i  (inc_i),
        .dec_i  (dec_i),
        .step_o (step)
    );

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        localparam int WK  = stage_width(k, W0);
        localparam int OFF = stage_offset(k, W0);
        localparam int NZ  = WK / 4;
        logic                 s_vld;
        logic signed [WK-1:0] s_val;

        if (k == 0) begin : g_first
            updn_stage #(.WI(2), .W(WK), .INVERT(1'b1)) u_st (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_vld  (1'b1),
                .in_val  (step),
                .out_vld (s_vld),
                .out_val (s_val),
                .word_o  (word_o[OFF +: WK])
            );
        end else begin : g_next
            localparam int WP   = stage_width(k - 1, W0);
            localparam int OFFP = stage_offset(k - 1, W0);
            updn_stage #(.WI(WP), .W(WK), .INVERT((k % 2) == 0)) u_st (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_vld  (valid_o[k-1]),
                .in_val  ($signed(val_bus[OFFP +: WP])),
                .out_vld (s_vld),
                .out_val (s_val),
                .word_o  (word_o[OFF +: WK])
            );
        end

        assign valid_o[k]          = s_vld;
        assign val_bus[OFF +: WK]  = s_val;
        assign noise_o[OFF +: WK]  = WK'((1 << NZ) - 1);
    end
endmodule

// File: tb/sim_updn_decimator.sv
module sim_updn_decimator;
    localparam int NST = 4;
    localparam int W0  = 4;
    localparam int BW  = NST * W0 + NST * (NST - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inc_i = 1'b0;
    logic dec_i = 1'b0;
    logic [BW-1:0]  word_o;
    logic [NST-1:0] valid_o;
    logic [BW-1:0]  noise_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit running = 1'b0;
    bit done = 1'b0;
    string cur_tag = "R2";

    int m_prev [NST];
    int m_cnt  [NST];
    bit m_ph   [NST];
    int expq   [NST][$];
    int last_v [NST];
    int nvalid [NST];

    updn_decimator #(.NSTAGE(NST), .W0(W0)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (inc_i),
        .dec_i   (dec_i),
        .word_o  (word_o),
        .valid_o (valid_o),
        .noise_o (noise_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) if (running) cyc <= cyc + 1;

    function automatic int wid(int k);  return W0 + 2 * k;          endfunction
    function automatic int offs(int k); return k * W0 + k * (k - 1); endfunction
    function automatic int field(logic [BW-1:0] v, int k);
        logic [63:0] e;
        e = 64'(v) >> offs(k);
        return int'(e & ((64'd1 << wid(k)) - 1));
    endfunction
    function automatic int coded(int v, int k);
        int m;
        m = (1 << wid(k)) - 1;
        return ((k % 2) == 0) ? ((~v) & m) : (v & m);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Model one clock of the chain; pushes expected coded words
    task automatic model_step(bit inc, bit dec);
        int smp;
        bit carry;
        int acc;
        int lim;
        smp = (inc && !dec) ? 1 : ((dec && !inc) ? -1 : 0);
        carry = 1'b1;
        for (int k = 0; k < NST; k++) begin
            if (carry) begin
                acc = m_cnt[k] + smp + m_prev[k];
                m_prev[k] = smp;
                lim = (1 << (wid(k) - 1));
                if (acc > lim - 1) acc = lim - 1;
                if (acc < -lim) acc = -lim;
                if (m_ph[k]) begin
                    expq[k].push_back(coded(acc, k));
                    m_cnt[k] = 0;
                    m_ph[k] = 1'b0;
                    smp = acc;
                    carry = 1'b1;
                end else begin
                    m_cnt[k] = acc;
                    m_ph[k] = 1'b1;
                    carry = 1'b0;
                end
            end
        end
    endtask

    task automatic drive(bit inc, bit dec);
        inc_i = inc;
        dec_i = dec;
        model_step(inc, dec);
        @(negedge clk);
    endtask

    // Monitor: compares strobed words with the scoreboard queues
    always @(negedge clk) begin
        if (running && rst_n) begin
            for (int k = 0; k < NST; k++) begin
                if (valid_o[k]) begin
                    if (expq[k].size() == 0) begin
                        check(1'b0, "R5 unexpected strobe", k, -1);
                    end else begin
                        int e;
                        e = expq[k].pop_front();
                        check(field(word_o, k) == e,
                              $sformatf("%s R4 R6 R7 stage %0d word", cur_tag, k),
                              field(word_o, k), e);
                    end
                    if (nvalid[k] > 0)
                        check((cyc - last_v[k]) == (1 << (k + 1)),
                              $sformatf("R5 stage %0d strobe spacing", k),
                              cyc - last_v[k], 1 << (k + 1));
                    last_v[k] = cyc;
                    nvalid[k]++;
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NST; k++) begin
            m_prev[k] = 0; m_cnt[k] = 0; m_ph[k] = 1'b0;
            last_v[k] = 0; nvalid[k] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9 reset state, R8 noise mask
        check(valid_o == '0, "R9 valid after reset", int'(valid_o), 0);
        for (int k = 0; k < NST; k++) begin
            check(field(word_o, k) == coded(0, k), $sformatf("R9 stage %0d reset word", k),
                  field(word_o, k), coded(0, k));
            check(field(noise_o, k) == ((1 << (wid(k) / 4)) - 1),
                  $sformatf("R8 stage %0d noise mask", k),
                  field(noise_o, k), (1 << (wid(k) / 4)) - 1);
        end
        rst_n = 1'b1;
        running = 1'b1;
        // R1: simultaneous pulses cancel
        cur_tag = "R1";
        for (int i = 0; i < 64; i++) drive(1'b1, 1'b1);
        check(field(word_o, 0) == coded(0, 0), "R1 stage 0 after cancel run",
              field(word_o, 0), coded(0, 0));
        // R2: isolated single pulses, exercises pair averaging
        cur_tag = "R2";
        for (int i = 0; i < 96; i++) drive((i % 7) == 0, (i % 11) == 3);
        // R3: full scale up, then full scale down
        cur_tag = "R3";
        for (int i = 0; i < 128; i++) drive(1'b1, 1'b0);
        for (int i = 0; i < 128; i++) drive(1'b0, 1'b1);
        // Random streams
        cur_tag = "R4";
        for (int i = 0; i < 800; i++) drive(1'($urandom), 1'($urandom));
        cur_tag = "R5";
        for (int i = 0; i < 64; i++) drive(1'b0, 1'b0);
        for (int k = 0; k < NST; k++)
            check(nvalid[k] > 0, $sformatf("R5 stage %0d produced strobes", k), nvalid[k], 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule